// File: doc/BRIEF.md
# Shared Cache Maintenance Command Queue

This block is the register front-end through which several processors post cache maintenance work (invalidate, clean or flush) into one shared queue. Each access on the register port carries the number of the issuing processor as a sideband. A processor stages a command by writing a mode word, then optionally a start address and a byte count. It commits the command by reading its registration result. The shared staging registers are guarded by a lock: the first processor that writes the mode word owns them until it reads its registration result. The commit read pushes the staged command into a FIFO, or refuses it when the FIFO is full.

A stub executor takes queued commands in arrival order, one at a time. It holds each for a programmable number of cycles and then reports it on a retire strobe. Every processor has its own status word: a busy bit for its own outstanding work, an error bit reflecting its last registration attempt, and a completion flag that is raised when one of its commands asked for notification. A separate primitive register records drain and prefetch-flush requests. A read of that register is held off until the queue and the executor are both empty, so software can use it as a barrier.

Top module: `cmq_top`

## Requirements
- R1: A write to offset 0x248 (mode) is accepted when the lock is free or already held by the writer. It takes the lock and stages a command whose type is bits 1:0 (0 invalidate, 1 clean, 2 flush), whose scope is whole-cache exactly when bits 18:17 equal 1 (otherwise a range), and whose notify request is bit 15. The staged address and size are cleared to 0.
- R2: A mode write from a processor other than the lock holder fails. It sets that processor's registration result to 0x1 and leaves the lock and the staged command unchanged.
- R3: Writes to offset 0x24C (start address) and 0x250 (size) update the staged command only when they come from the lock holder while the staged scope is a range. In every other case they have no effect on the command that later retires.
- R4: A read of offset 0x25C by the lock holder releases the lock. When the queue holds QDEPTH entries it returns 0x2 (bit 1, full) and queues nothing. Otherwise it returns 0 and queues the staged command. All read data appears on rsp_rdata with rsp_valid in the cycle after the read is accepted.
- R5: Queued commands start one at a time in arrival order. Each occupies the executor for EXEC_DLY cycles, with done_valid high for exactly its last cycle while the done_* outputs show its processor, type, scope, address and size.
- R6: A read of offset 0x260 returns the reader's own status: bit 0 is set while that processor has commands queued or executing, bit 1 is set when its last registration result is nonzero, and bit 2 is its completion flag.
- R7: A retiring command with notify set raises the completion flag of its issuing processor only. A processor clears its own flag by writing offset 0x260 with bit 2 set; a retire in the same cycle wins.
- R8: A write to offset 0x244 stores data bits 3:0 (0x8 drain, 0x9 prefetch flush). A read of 0x244 keeps req_ready low while any command is queued or executing, and then returns the stored code.
- R9: After reset the lock is free, the queue and executor are empty, every status word and registration result is 0, and req_ready is high.
- R10: A read of offset 0x25C by a processor that does not hold the lock returns that processor's last registration result and leaves the lock held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Register access request |
| req_write | input | 1 | 1 write, 0 read |
| req_cpu | input | CPU_W | Issuing processor number |
| req_offs | input | 12 | Register offset |
| req_wdata | input | 32 | Write data |
| req_ready | output | 1 | Access accepted this cycle when high with req_valid |
| rsp_valid | output | 1 | Read data valid |
| rsp_rdata | output | 32 | Read data |
| done_valid | output | 1 | A command retires this cycle |
| done_cpu | output | CPU_W | Issuing processor of the retiring command |
| done_cmd | output | 2 | Command type of the retiring command |
| done_whole | output | 1 | Retiring command covers the whole cache |
| done_addr | output | ADDR_W | Start address of the retiring command |
| done_size | output | ADDR_W | Size of the retiring command |

## Verification
req_ready responds in the same cycle as the request, read data follows one cycle after the accepting edge, and a committed command is taken by the executor on the next edge and shows done_valid in its EXEC_DLY-th cycle there. The completion flag and busy bit change on the retire edge and so are seen by the first read after it. The bench steps a behavioural model on each rising edge with the same inputs the design sees. It compares every output one nanosecond before the next rising edge, so each registered result is checked in exactly the cycle it is due. Directed reads then confirm the lock contention, full-queue refusal, whole-cache field suppression and drain-barrier cases with literal values.

// File: rtl/cmq_pkg.sv
package cmq_pkg;
  localparam int DATA_W = 32;
  localparam int OFS_W  = 12;

  localparam logic [OFS_W-1:0] OFS_PRIM  = 12'h244;
  localparam logic [OFS_W-1:0] OFS_MODE  = 12'h248;
  localparam logic [OFS_W-1:0] OFS_ADDR  = 12'h24C;
  localparam logic [OFS_W-1:0] OFS_SIZE  = 12'h250;
  localparam logic [OFS_W-1:0] OFS_RSTAT = 12'h25C;
  localparam logic [OFS_W-1:0] OFS_QSTAT = 12'h260;

  localparam int MODE_SCOPE_LO = 17;
  localparam int MODE_NOTIFY   = 15;
  localparam int QST_DONE      = 2;

  localparam logic [1:0] SCOPE_WHOLE = 2'b01;
  localparam logic [1:0] RES_FAIL    = 2'b01;
endpackage

// File: rtl/cmq_fifo.sv
module cmq_fifo #(
  parameter int DW    = 8,
  parameter int DEPTH = 4,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic             pop,
  input  logic [DW-1:0]    din,
  output logic [DW-1:0]    dout,
  output logic             empty,
  output logic             full,
  output logic [CNT_W-1:0] count
);
  logic [DW-1:0]    mem [DEPTH];
  logic [PTR_W-1:0] wp_q, wp_n, rp_q, rp_n;
  logic [CNT_W-1:0] cnt_q, cnt_n;

  function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_comb begin
    wp_n  = push ? bump(wp_q) : wp_q;
    rp_n  = pop  ? bump(rp_q) : rp_q;
    cnt_n = cnt_q;
    case ({push, pop})
      2'b10:   cnt_n = cnt_q + 1'b1;
      2'b01:   cnt_n = cnt_q - 1'b1;
      default: cnt_n = cnt_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      wp_q  <= wp_n;
      rp_q  <= rp_n;
      cnt_q <= cnt_n;
    end
  end

  always_ff @(posedge clk) begin
    if (push) mem[wp_q] <= din;
  end

  assign dout  = mem[rp_q];
  assign empty = (cnt_q == '0);
  assign full  = (cnt_q == CNT_W'(DEPTH));
  assign count = cnt_q;
endmodule

// File: rtl/cmq_exec.sv
module cmq_exec #(
  parameter int DW  = 8,
  parameter int DLY = 4,
  localparam int CW = $clog2(DLY + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          avail,
  input  logic [DW-1:0] din,
  output logic          pop,
  output logic          busy,
  output logic          fire,
  output logic [DW-1:0] dout
);
  logic          run_q, run_n;
  logic [CW-1:0] cnt_q, cnt_n;
  logic [DW-1:0] ent_q;

  assign pop  = !run_q && avail;
  assign fire = run_q && (cnt_q == '0);
  assign busy = run_q;
  assign dout = ent_q;

  always_comb begin
    run_n = run_q;
    cnt_n = cnt_q;
    if (pop) begin
      run_n = 1'b1;
      cnt_n = CW'(DLY - 1);
    end else if (fire) begin
      run_n = 1'b0;
    end else if (run_q) begin
      cnt_n = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= 1'b0;
      cnt_q <= '0;
    end else begin
      run_q <= run_n;
      cnt_q <= cnt_n;
    end
  end

  always_ff @(posedge clk) begin
    if (pop) ent_q <= din;
  end
endmodule

// File: rtl/cmq_cpu_stat.sv
module cmq_cpu_stat #(
  parameter int PW = 3
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       fail_set,
  input  logic       res_load,
  input  logic [1:0] res_val,
  input  logic       done_set,
  input  logic       done_clr,
  input  logic       inc,
  input  logic       dec,
  output logic [1:0] res,
  output logic       done,
  output logic       pend_nz
);
  logic [1:0]    res_q, res_n;
  logic          done_q, done_n;
  logic [PW-1:0] pend_q, pend_n;

  always_comb begin
    res_n = res_q;
    if (res_load)      res_n = res_val;
    else if (fail_set) res_n = cmq_pkg::RES_FAIL;
    done_n = done_q;
    if (done_set)      done_n = 1'b1;
    else if (done_clr) done_n = 1'b0;
    case ({inc, dec})
      2'b10:   pend_n = pend_q + 1'b1;
      2'b01:   pend_n = pend_q - 1'b1;
      default: pend_n = pend_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_q  <= '0;
      done_q <= 1'b0;
      pend_q <= '0;
    end else begin
      res_q  <= res_n;
      done_q <= done_n;
      pend_q <= pend_n;
    end
  end

  assign res     = res_q;
  assign done    = done_q;
  assign pend_nz = (pend_q != '0);
endmodule

// File: rtl/cmq_top.sv
module cmq_top
  import cmq_pkg::*;
#(
  parameter int NCPU     = 2,
  parameter int QDEPTH   = 4,
  parameter int ADDR_W   = 32,
  parameter int EXEC_DLY = 4,
  localparam int CPU_W = (NCPU > 1) ? $clog2(NCPU) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [CPU_W-1:0]  req_cpu,
  input  logic [OFS_W-1:0]  req_offs,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              req_ready,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              done_valid,
  output logic [CPU_W-1:0]  done_cpu,
  output logic [1:0]        done_cmd,
  output logic              done_whole,
  output logic [ADDR_W-1:0] done_addr,
  output logic [ADDR_W-1:0] done_size
);
  localparam int ENT_W  = CPU_W + 4 + 2 * ADDR_W;
  localparam int CNT_W  = $clog2(QDEPTH + 1);
  localparam int PEND_W = $clog2(QDEPTH + 2);
  localparam int B_NT   = 2 * ADDR_W;
  localparam int B_WH   = B_NT + 1;
  localparam int B_CMD  = B_NT + 2;
  localparam int B_CPU  = B_NT + 4;

  // reset: asynchronous assert, synchronous release
  logic [1:0] rsync_q;
  logic       rst_q_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_q_n = rsync_q[1];

  // lock, staging and primitive registers
  logic              lock_v_q, lock_v_n;
  logic [CPU_W-1:0]  lock_cpu_q, lock_cpu_n;
  logic [1:0]        sh_cmd_q, sh_cmd_n;
  logic              sh_whole_q, sh_whole_n, sh_notify_q, sh_notify_n;
  logic [ADDR_W-1:0] sh_addr_q, sh_addr_n, sh_size_q, sh_size_n;
  logic [3:0]        prim_q, prim_n;
  logic              rsp_v_q, rsp_v_n;
  logic [DATA_W-1:0] rsp_d_q, rsp_d_n, rd_val;

  // queue and executor
  logic             fifo_push, fifo_pop, fifo_empty, fifo_full;
  logic [CNT_W-1:0] fifo_count;
  logic [ENT_W-1:0] ent_in, fifo_dout, exe_dout;
  logic             exe_busy, exe_fire, busy_any;

  // per-processor status
  logic [1:0]      res_v [NCPU];
  logic [NCPU-1:0] done_v, pend_v;

  // decode
  logic acc, wr, rd, is_owner, take, deny, release_rd, addr_wr, size_wr;
  logic prim_rd, qstat_clr;
  assign busy_any   = !fifo_empty || exe_busy;
  assign prim_rd    = req_valid && !req_write && (req_offs == OFS_PRIM);
  assign req_ready  = !(prim_rd && busy_any);
  assign acc        = req_valid && req_ready;
  assign wr         = acc && req_write;
  assign rd         = acc && !req_write;
  assign is_owner   = lock_v_q && (lock_cpu_q == req_cpu);
  assign take       = wr && (req_offs == OFS_MODE) && (!lock_v_q || is_owner);
  assign deny       = wr && (req_offs == OFS_MODE) && lock_v_q && !is_owner;
  assign addr_wr    = wr && (req_offs == OFS_ADDR) && is_owner && !sh_whole_q;
  assign size_wr    = wr && (req_offs == OFS_SIZE) && is_owner && !sh_whole_q;
  assign release_rd = rd && (req_offs == OFS_RSTAT) && is_owner;
  assign qstat_clr  = wr && (req_offs == OFS_QSTAT) && req_wdata[QST_DONE];
  assign fifo_push  = release_rd && !fifo_full;
  assign ent_in     = {lock_cpu_q, sh_cmd_q, sh_whole_q, sh_notify_q, sh_addr_q, sh_size_q};

  cmq_fifo #(.DW(ENT_W), .DEPTH(QDEPTH)) u_fifo (
    .clk(clk), .rst_n(rst_q_n), .push(fifo_push), .pop(fifo_pop), .din(ent_in),
    .dout(fifo_dout), .empty(fifo_empty), .full(fifo_full), .count(fifo_count)
  );

  cmq_exec #(.DW(ENT_W), .DLY(EXEC_DLY)) u_exec (
    .clk(clk), .rst_n(rst_q_n), .avail(!fifo_empty), .din(fifo_dout),
    .pop(fifo_pop), .busy(exe_busy), .fire(exe_fire), .dout(exe_dout)
  );

  for (genvar g = 0; g < NCPU; g++) begin : g_cpu
    logic hit, own_done;
    assign hit      = (req_cpu == CPU_W'(g));
    assign own_done = exe_fire && (exe_dout[ENT_W-1:B_CPU] == CPU_W'(g));
    cmq_cpu_stat #(.PW(PEND_W)) u_stat (
      .clk(clk), .rst_n(rst_q_n),
      .fail_set(deny && hit), .res_load(release_rd && hit),
      .res_val({fifo_full, 1'b0}),
      .done_set(own_done && exe_dout[B_NT]), .done_clr(qstat_clr && hit),
      .inc(fifo_push && hit), .dec(own_done),
      .res(res_v[g]), .done(done_v[g]), .pend_nz(pend_v[g])
    );
  end

  always_comb begin
    rd_val = '0;
    case (req_offs)
      OFS_RSTAT: rd_val = is_owner ? DATA_W'({fifo_full, 1'b0}) : DATA_W'(res_v[req_cpu]);
      OFS_QSTAT: rd_val = DATA_W'({done_v[req_cpu], |res_v[req_cpu], pend_v[req_cpu]});
      OFS_PRIM:  rd_val = DATA_W'(prim_q);
      default:   rd_val = '0;
    endcase
  end

  always_comb begin
    lock_v_n    = lock_v_q;
    lock_cpu_n  = lock_cpu_q;
    sh_cmd_n    = sh_cmd_q;
    sh_whole_n  = sh_whole_q;
    sh_notify_n = sh_notify_q;
    sh_addr_n   = sh_addr_q;
    sh_size_n   = sh_size_q;
    prim_n      = prim_q;
    if (take) begin
      lock_v_n    = 1'b1;
      lock_cpu_n  = req_cpu;
      sh_cmd_n    = req_wdata[1:0];
      sh_whole_n  = (req_wdata[MODE_SCOPE_LO+1:MODE_SCOPE_LO] == SCOPE_WHOLE);
      sh_notify_n = req_wdata[MODE_NOTIFY];
      sh_addr_n   = '0;
      sh_size_n   = '0;
    end
    if (release_rd) lock_v_n = 1'b0;
    if (addr_wr) sh_addr_n = req_wdata[ADDR_W-1:0];
    if (size_wr) sh_size_n = req_wdata[ADDR_W-1:0];
    if (wr && (req_offs == OFS_PRIM)) prim_n = req_wdata[3:0];
    rsp_v_n = rd;
    rsp_d_n = rd ? rd_val : rsp_d_q;
  end

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      lock_v_q    <= 1'b0;
      lock_cpu_q  <= '0;
      sh_cmd_q    <= '0;
      sh_whole_q  <= 1'b0;
      sh_notify_q <= 1'b0;
      sh_addr_q   <= '0;
      sh_size_q   <= '0;
      prim_q      <= '0;
      rsp_v_q     <= 1'b0;
      rsp_d_q     <= '0;
    end else begin
      lock_v_q    <= lock_v_n;
      lock_cpu_q  <= lock_cpu_n;
      sh_cmd_q    <= sh_cmd_n;
      sh_whole_q  <= sh_whole_n;
      sh_notify_q <= sh_notify_n;
      sh_addr_q   <= sh_addr_n;
      sh_size_q   <= sh_size_n;
      prim_q      <= prim_n;
      rsp_v_q     <= rsp_v_n;
      rsp_d_q     <= rsp_d_n;
    end
  end

  assign rsp_valid  = rsp_v_q;
  assign rsp_rdata  = rsp_d_q;
  assign done_valid = exe_fire;
  assign done_cpu   = exe_dout[ENT_W-1:B_CPU];
  assign done_cmd   = exe_dout[B_CMD+1:B_CMD];
  assign done_whole = exe_dout[B_WH];
  assign done_addr  = exe_dout[2*ADDR_W-1:ADDR_W];
  assign done_size  = exe_dout[ADDR_W-1:0];

  logic unused_cnt;
  assign unused_cnt = ^fifo_count;
endmodule

// File: rtl/cmq_chk.sv
module cmq_chk #(
  parameter int QDEPTH = 4,
  parameter int CNT_W  = 3,
  parameter int ADDR_W = 32,
  parameter int CPU_W  = 1
) (
  input logic              clk,
  input logic              rst_n,
  input logic [CNT_W-1:0]  fifo_count,
  input logic              fifo_full,
  input logic              release_rd,
  input logic              exe_busy,
  input logic              done_valid,
  input logic              req_ready,
  input logic              deny,
  input logic              lock_v,
  input logic [CPU_W-1:0]  lock_cpu,
  input logic              wr,
  input logic [11:0]       req_offs,
  input logic              is_owner,
  input logic [ADDR_W-1:0] sh_addr
);
  // R4: queue occupancy bounded; a refused commit never grows the queue
  p_no_overflow_r4: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_count <= CNT_W'(QDEPTH));
  p_full_refused_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (release_rd && fifo_full) |=> (fifo_count <= $past(fifo_count)));
  // R5: retires are single-cycle strobes, never back to back
  p_single_retire_r5: assert property (@(posedge clk) disable iff (!rst_n)
    done_valid |=> !done_valid);
  // R2: a refused mode write leaves the lock with its holder
  p_deny_keeps_lock_r2: assert property (@(posedge clk) disable iff (!rst_n)
    deny |=> (lock_v && $stable(lock_cpu)));
  // R8: stalls only while work is outstanding
  p_stall_only_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !req_ready |-> (fifo_count != '0 || exe_busy));
  // R3: address writes from a non-holder leave the staged address alone
  p_foreign_addr_ignored_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && req_offs == cmq_pkg::OFS_ADDR && !is_owner) |=> $stable(sh_addr));
endmodule

bind cmq_top cmq_chk #(
  .QDEPTH(QDEPTH), .CNT_W(CNT_W), .ADDR_W(ADDR_W), .CPU_W(CPU_W)
) u_chk (
  .clk(clk), .rst_n(rst_q_n), .fifo_count(fifo_count), .fifo_full(fifo_full),
  .release_rd(release_rd), .exe_busy(exe_busy), .done_valid(done_valid),
  .req_ready(req_ready), .deny(deny), .lock_v(lock_v_q), .lock_cpu(lock_cpu_q),
  .wr(wr), .req_offs(req_offs), .is_owner(is_owner), .sh_addr(sh_addr_q)
);

// File: tb/sim_cmq_top.sv
module sim_cmq_top;
  localparam int QD  = 4;
  localparam int DLY = 40;

  logic        clk, rst_n;
  logic        req_valid, req_write;
  logic [0:0]  req_cpu;
  logic [11:0] req_offs;
  logic [31:0] req_wdata;
  logic        req_ready, rsp_valid, done_valid, done_whole;
  logic [31:0] rsp_rdata, done_addr, done_size;
  logic [0:0]  done_cpu;
  logic [1:0]  done_cmd;

  cmq_top #(.NCPU(2), .QDEPTH(QD), .ADDR_W(32), .EXEC_DLY(DLY)) u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_cpu(req_cpu), .req_offs(req_offs), .req_wdata(req_wdata),
    .req_ready(req_ready), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .done_valid(done_valid), .done_cpu(done_cpu), .done_cmd(done_cmd),
    .done_whole(done_whole), .done_addr(done_addr), .done_size(done_size)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  int n_chk = 0, n_fail = 0;
  bit chk_on = 0;

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %0h expected %0h", tag, act, exp);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  int          q_cpu[$], q_cmd[$];
  bit          q_wh[$], q_nt[$];
  logic [31:0] q_ad[$], q_sz[$];
  bit          m_lock, s_wh, s_nt;
  int          m_own, s_cmd;
  logic [31:0] s_ad, s_sz;
  int          m_res[2], m_pend[2];
  bit          m_done[2];
  bit          r_v, r_wh, r_nt;
  int          r_cnt, r_cpu, r_cmd;
  logic [31:0] r_ad, r_sz;
  int          m_prim;
  bit          m_rsp_v;
  logic [31:0] m_rsp_d;
  string       m_rsp_tag = "R4";

  function automatic bit m_busy();
    return (q_cpu.size() != 0) || r_v;
  endfunction

  function automatic bit m_ready();
    return !(req_valid && !req_write && req_offs == 12'h244 && m_busy());
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      q_cpu.delete(); q_cmd.delete(); q_wh.delete(); q_nt.delete();
      q_ad.delete(); q_sz.delete();
      m_lock = 0; m_own = 0; s_cmd = 0; s_wh = 0; s_nt = 0; s_ad = 0; s_sz = 0;
      for (int i = 0; i < 2; i++) begin m_res[i] = 0; m_pend[i] = 0; m_done[i] = 0; end
      r_v = 0; r_cnt = 0; m_prim = 0; m_rsp_v = 0; m_rsp_d = 0;
    end else begin
      bit acc, own, full_pre;
      int c;
      acc = req_valid && m_ready();
      c = int'(req_cpu);
      own = m_lock && (m_own == c);
      full_pre = (q_cpu.size() == QD);
      m_rsp_v = acc && !req_write;
      if (m_rsp_v) begin
        case (req_offs)
          12'h25C: begin m_rsp_d = own ? (full_pre ? 2 : 0) : m_res[c]; m_rsp_tag = own ? "R4" : "R10"; end
          12'h260: begin m_rsp_d = {29'd0, m_done[c], m_res[c] != 0, m_pend[c] != 0}; m_rsp_tag = "R6"; end
          12'h244: begin m_rsp_d = m_prim; m_rsp_tag = "R8"; end
          default: begin m_rsp_d = 0; m_rsp_tag = "R4"; end
        endcase
      end
      if (acc && req_write && req_offs == 12'h260 && req_wdata[2]) m_done[c] = 0;
      if (r_v && r_cnt == 0) begin
        r_v = 0; m_pend[r_cpu]--;
        if (r_nt) m_done[r_cpu] = 1;
      end else if (r_v) begin
        r_cnt--;
      end else if (q_cpu.size() != 0) begin
        r_cpu = q_cpu.pop_front(); r_cmd = q_cmd.pop_front(); r_wh = q_wh.pop_front();
        r_nt = q_nt.pop_front(); r_ad = q_ad.pop_front(); r_sz = q_sz.pop_front();
        r_v = 1; r_cnt = DLY - 1;
      end
      if (acc && req_write) begin
        case (req_offs)
          12'h248: if (!m_lock || own) begin
                     m_lock = 1; m_own = c; s_cmd = int'(req_wdata[1:0]);
                     s_wh = (req_wdata[18:17] == 2'b01); s_nt = req_wdata[15];
                     s_ad = 0; s_sz = 0;
                   end else m_res[c] = 1;
          12'h24C: if (own && !s_wh) s_ad = req_wdata;
          12'h250: if (own && !s_wh) s_sz = req_wdata;
          12'h244: m_prim = int'(req_wdata[3:0]);
          default: ;
        endcase
      end
      if (acc && !req_write && req_offs == 12'h25C && own) begin
        m_res[c] = full_pre ? 2 : 0;
        m_lock = 0;
        if (!full_pre) begin
          q_cpu.push_back(c); q_cmd.push_back(s_cmd); q_wh.push_back(s_wh);
          q_nt.push_back(s_nt); q_ad.push_back(s_ad); q_sz.push_back(s_sz);
          m_pend[c]++;
        end
      end
    end
  end

  // per-cycle comparison, 1 ns before the next rising edge
  always @(negedge clk) begin
    #4;
    if (chk_on) begin
      chk("R8 ready", req_ready, m_ready());
      chk("R5 retire", done_valid, r_v && r_cnt == 0);
      if (r_v && r_cnt == 0) begin
        chk("R5 cpu", done_cpu, r_cpu);
        chk("R1 cmd", done_cmd, r_cmd);
        chk("R1 scope", done_whole, r_wh);
        chk("R3 addr", done_addr, r_ad);
        chk("R3 size", done_size, r_sz);
      end
      chk({m_rsp_tag, " rsp_valid"}, rsp_valid, m_rsp_v);
      if (m_rsp_v) chk({m_rsp_tag, " rdata"}, rsp_rdata, m_rsp_d);
    end
  end

  // ---------------- stimulus ----------------
  task automatic acc_req(input int cpu, input bit w, input logic [11:0] o,
                         input logic [31:0] d, output logic [31:0] rdat, output int stalls);
    @(negedge clk);
    req_valid = 1; req_write = w; req_cpu = cpu[0:0]; req_offs = o; req_wdata = d;
    stalls = 0;
    #4;
    while (!req_ready) begin stalls++; @(negedge clk); #4; end
    @(negedge clk);
    req_valid = 0;
    rdat = rsp_rdata;
  endtask

  task automatic wr(input int cpu, input logic [11:0] o, input logic [31:0] d);
    logic [31:0] x; int s;
    acc_req(cpu, 1'b1, o, d, x, s);
  endtask

  task automatic rd(input int cpu, input logic [11:0] o, output logic [31:0] v);
    int s;
    acc_req(cpu, 1'b0, o, 32'h0, v, s);
  endtask

  task automatic wait_done();
    do begin @(negedge clk); #4; end while (!done_valid);
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL R5 watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    logic [31:0] v;
    int st;
    rst_n = 0; req_valid = 0; req_write = 0; req_cpu = 0; req_offs = 0; req_wdata = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);
    chk_on = 1;
    #4;
    chk("R9 ready", req_ready, 1);
    chk("R9 rsp_valid", rsp_valid, 0);

    rd(0, 12'h260, v); chk("R9 qstat cpu0", v, 0);
    rd(1, 12'h25C, v); chk("R9 rstat cpu1", v, 0);

    // range flush with notify from cpu0
    wr(0, 12'h248, 32'h0000_8002);
    wr(0, 12'h24C, 32'h0000_1000);
    wr(0, 12'h250, 32'h0000_0080);
    rd(0, 12'h25C, v); chk("R4 commit ok", v, 0);
    wait_done();
    chk("R1 cmd flush", done_cmd, 2);
    chk("R1 range scope", done_whole, 0);
    chk("R3 owner addr", done_addr, 32'h1000);
    chk("R5 done cpu", done_cpu, 0);
    rd(0, 12'h260, v); chk("R7 flag own cpu", v, 4);
    rd(1, 12'h260, v); chk("R7 flag other cpu", v, 0);
    wr(0, 12'h260, 32'h4);
    rd(0, 12'h260, v); chk("R7 flag cleared", v, 0);

    // lock contention
    wr(0, 12'h248, 32'h0000_0001);
    wr(1, 12'h248, 32'h0000_8000);
    wr(1, 12'h24C, 32'h000D_EAD0);
    wr(0, 12'h24C, 32'h0000_2000);
    wr(0, 12'h250, 32'h0000_0040);
    rd(1, 12'h25C, v); chk("R2 R10 refused", v, 1);
    rd(1, 12'h260, v); chk("R6 error bit", v, 2);
    rd(0, 12'h25C, v); chk("R4 holder commit", v, 0);
    wait_done();
    chk("R3 foreign addr ignored", done_addr, 32'h2000);
    chk("R1 cmd clean", done_cmd, 1);
    rd(0, 12'h260, v); chk("R7 no notify no flag", v, 0);

    // whole-cache command ignores address and size
    wr(1, 12'h248, 32'h0002_8000);
    wr(1, 12'h24C, 32'h0000_3000);
    wr(1, 12'h250, 32'h0000_0010);
    rd(1, 12'h25C, v); chk("R4 whole commit", v, 0);
    wait_done();
    chk("R1 whole scope", done_whole, 1);
    chk("R3 whole addr", done_addr, 0);
    chk("R3 whole size", done_size, 0);
    rd(1, 12'h260, v); chk("R7 R6 cpu1 flag", v, 4);

    // fill the queue
    for (int i = 0; i < 6; i++) begin
      wr(0, 12'h248, 32'h0002_0002);
      rd(0, 12'h25C, v);
      chk("R4 fill result", v, (i == 5) ? 2 : 0);
    end
    rd(0, 12'h260, v); chk("R6 busy and error", v, 3);

    // drain barrier
    wr(1, 12'h244, 32'h8);
    acc_req(1, 1'b0, 12'h244, 32'h0, v, st);
    chk("R8 drain code", v, 8);
    chk("R8 stalled", st > 0, 1);
    rd(0, 12'h260, v); chk("R6 idle after drain", v, 2);
    wr(1, 12'h244, 32'h9);
    acc_req(1, 1'b0, 12'h244, 32'h0, v, st);
    chk("R8 prefetch code", v, 9);
    chk("R8 no stall when idle", st, 0);

    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule